// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block holds the interrupt flags and enables for a small 8-bit microcontroller core. It watches three sources: an external pin with a selectable active edge, a one-cycle overflow pulse from an 8-bit timer, and a change detector on four port pins. Each source sets its own flag in an 8-bit control register. Only a software write clears a flag.

Two outputs come from the flags. The request output combines the flags with their enables and the global enable, and it asks the core to branch to a fixed vector. The wake output ignores the global enable, so any enabled source can bring the core out of sleep. Whether the core then vectors depends on the global enable alone. Taking the interrupt clears the global enable, and a return-from-interrupt pulse sets it again.

The change detector compares the synchronized port pins against a copy captured on each port read. When a pin change reaches the comparator in the same cycle as a read, the capture wins and the change is never flagged.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, and `irq_o` and `wake_o` are 0.
- R2: When `edge_rise_i` is 1, a rising transition on `ext_pin_i` sets the external flag (register bit 1), and a falling transition does not. The flag appears in the register three clock edges after the pin changes.
- R3: When `edge_rise_i` is 0, a falling transition on `ext_pin_i` sets the external flag, and a rising transition does not.
- R4: Changing `edge_rise_i` while `ext_pin_i` is steady never sets the external flag.
- R5: A one-cycle `tmr_ovf_i` pulse sets the timer flag (bit 2) at the next edge. This also happens when a register write in the same cycle clears that flag.
- R6: When any of the four synchronized `port_i` bits differs from the value captured at the last `port_rd_i`, the change flag (bit 0) is set. After a read the pins match again, and the flag stays clear once software has cleared it.
- R7: If the synchronized pin change and `port_rd_i` fall in the same cycle, the capture takes the new value and the change flag is not set. A read one cycle earlier does not hide the change.
- R8: Flags are never cleared by hardware, and that includes `irq_ack_i`. A register write loads every writable bit, so writing 1 to a flag bit sets it.
- R9: `irq_o` equals GIE (bit 7) AND the OR of the three flag/enable pairs. The pairs are timer flag bit 2 with enable bit 5, external flag bit 1 with enable bit 4, and change flag bit 0 with enable bit 3.
- R10: `wake_o` equals `sleep_i` AND the same OR of flag/enable pairs, whatever the value of GIE.
- R11: `irq_ack_i` clears GIE at the next edge, and `irq_ret_i` sets it. A register write takes priority over both, and acknowledge takes priority over return. `irq_vec_o` is constant 0x004.
- R12: Register bit 6 is not implemented and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| edge_rise_i | input | 1 | Edge select: 1 for rising, 0 for falling |
| tmr_ovf_i | input | 1 | Timer overflow pulse, one cycle |
| port_i | input | 4 | Port pins watched for change, asynchronous |
| port_rd_i | input | 1 | Port read strobe, captures the compare value |
| reg_we_i | input | 1 | Control register write enable |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register contents |
| sleep_i | input | 1 | Core is asleep |
| irq_ack_i | input | 1 | Core is taking the interrupt |
| irq_ret_i | input | 1 | Return from interrupt |
| irq_o | output | 1 | Vector request to the core |
| wake_o | output | 1 | Wake request to the sleep logic |
| irq_vec_o | output | 13 | Interrupt vector address |

## Verification
The hardest case to reach from the ports is the read race of R7. The port read has to arrive in exactly the cycle in which a pin change leaves the two-stage synchronizer. The bench changes one port bit at a falling edge and waits two rising edges. It then raises `port_rd_i` for one cycle and checks that the change flag stays clear. It repeats the sequence with the read one cycle earlier and expects the flag to be set. That early case shows the first check is a true race and not a detector that does nothing. The full sweep covers all 256 register values at both sleep levels against the arithmetic model of R9 and R10.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_W = 8;

  typedef struct packed {
    logic gie;
    logic rsv;
    logic tmr_en;
    logic ext_en;
    logic chg_en;
    logic tmr_flag;
    logic ext_flag;
    logic chg_flag;
  } ctrl_t;

  typedef struct packed {
    logic tmr;
    logic ext;
    logic chg;
  } src_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stg[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= src;
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irq_ext_edge.sv
module irq_ext_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  logic pin_s, pin_q;

  irq_sync #(.W(1), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_s;
  end

  // Compare the level history itself. The select only picks which
  // transition counts, so toggling it on a steady pin creates no edge.
  always_comb begin
    if (rise_sel_i) hit_o = pin_s & ~pin_q;
    else            hit_o = ~pin_s & pin_q;
  end
endmodule

// File: rtl/irq_port_chg.sv
module irq_port_chg #(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] port_i,
  input  logic              rd_i,
  output logic              hit_o
);
  logic [PORT_W-1:0] port_s, snap_q;

  irq_sync #(.W(PORT_W), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (port_i),
    .q_o   (port_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   snap_q <= '0;
    else if (rd_i) snap_q <= port_s;
  end

  // In a read cycle the capture wins and the compare is dropped.
  assign hit_o = (port_s != snap_q) & ~rd_i;
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  src_t        set_i,
  input  logic        we_i,
  input  logic [7:0]  wdata_i,
  input  logic        ack_i,
  input  logic        ret_i,
  output ctrl_t       ctrl_o
);
  ctrl_t cur_q, wr_v, nxt;
  logic  unused_rsv;

  assign unused_rsv = wdata_i[6];

  always_comb begin
    wr_v     = ctrl_t'(wdata_i);
    wr_v.rsv = 1'b0;
    nxt      = we_i ? wr_v : cur_q;
    if (!we_i) begin
      if (ack_i)      nxt.gie = 1'b0;
      else if (ret_i) nxt.gie = 1'b1;
    end
    // A hardware set beats a software clear in the same cycle.
    nxt.tmr_flag = nxt.tmr_flag | set_i.tmr;
    nxt.ext_flag = nxt.ext_flag | set_i.ext;
    nxt.chg_flag = nxt.chg_flag | set_i.chg;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= nxt;
  end

  assign ctrl_o = cur_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned PORT_W   = 4,
  parameter int unsigned STAGES   = 2,
  parameter int unsigned VEC_W    = 13,
  parameter int unsigned VEC_ADDR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_pin_i,
  input  logic              edge_rise_i,
  input  logic              tmr_ovf_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              port_rd_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              sleep_i,
  input  logic              irq_ack_i,
  input  logic              irq_ret_i,
  output logic              irq_o,
  output logic              wake_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  localparam logic [VEC_W-1:0] VEC = VEC_W'(VEC_ADDR);

  src_t  set;
  ctrl_t ctrl;
  logic  pend;

  irq_ext_edge #(.STAGES(STAGES)) u_ext (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (ext_pin_i),
    .rise_sel_i(edge_rise_i),
    .hit_o     (set.ext)
  );

  irq_port_chg #(.PORT_W(PORT_W), .STAGES(STAGES)) u_chg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .port_i(port_i),
    .rd_i  (port_rd_i),
    .hit_o (set.chg)
  );

  assign set.tmr = tmr_ovf_i;

  irq_ctrl_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .ack_i  (irq_ack_i),
    .ret_i  (irq_ret_i),
    .ctrl_o (ctrl)
  );

  assign pend = (ctrl.tmr_flag & ctrl.tmr_en)
              | (ctrl.ext_flag & ctrl.ext_en)
              | (ctrl.chg_flag & ctrl.chg_en);

  assign irq_o       = ctrl.gie & pend;
  assign wake_o      = sleep_i & pend;
  assign reg_rdata_o = ctrl;
  assign irq_vec_o   = VEC;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tmr_ovf_i,
  input logic       reg_we_i,
  input logic [7:0] reg_rdata_o,
  input logic       sleep_i,
  input logic       irq_ack_i,
  input logic       irq_ret_i,
  input logic       irq_o,
  input logic       wake_o
);
  a_r8_no_hw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> ((reg_rdata_o[2:0] & $past(reg_rdata_o[2:0])) == $past(reg_rdata_o[2:0])));

  a_r5_tmr_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> reg_rdata_o[2]);

  a_r9_irq_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> reg_rdata_o[7]);

  a_r10_wake_needs_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> sleep_i);

  a_r10_sleep_irq_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && irq_o) |-> wake_o);

  a_r11_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !reg_we_i) |=> !reg_rdata_o[7]);

  a_r11_ret_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && !irq_ack_i && !reg_we_i) |=> reg_rdata_o[7]);

  a_r12_bit6_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[6]);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tmr_ovf_i  (tmr_ovf_i),
  .reg_we_i   (reg_we_i),
  .reg_rdata_o(reg_rdata_o),
  .sleep_i    (sleep_i),
  .irq_ack_i  (irq_ack_i),
  .irq_ret_i  (irq_ret_i),
  .irq_o      (irq_o),
  .wake_o     (wake_o)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_pin = 1'b0, edge_rise = 1'b0, tmr_ovf = 1'b0;
  logic [3:0]  port = '0;
  logic        port_rd = 1'b0, we = 1'b0, sleep = 1'b0, ack = 1'b0, ret = 1'b0;
  logic [7:0]  wdata = '0, rdata;
  logic        irq, wake;
  logic [12:0] vec;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ext_pin_i(ext_pin), .edge_rise_i(edge_rise),
    .tmr_ovf_i(tmr_ovf), .port_i(port), .port_rd_i(port_rd), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sleep_i(sleep), .irq_ack_i(ack),
    .irq_ret_i(ret), .irq_o(irq), .wake_o(wake), .irq_vec_o(vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    we = 1'b1; wdata = v; cyc(1); we = 1'b0;
  endtask

  task automatic rd_port();
    port_rd = 1'b1; cyc(1); port_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_tb();
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 reg", rdata, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 wake", wake, 1'b0);
    chk("R11 vec", vec, 13'h004);

    // R9 R10 R12 sweep over every register value and both sleep levels
    for (int v = 0; v < 256; v++) begin
      for (int s = 0; s < 2; s++) begin
        logic [7:0] vv;
        logic       pend;
        vv = 8'(v);
        sleep = s[0];
        wr(vv);
        pend = |(vv[2:0] & vv[5:3]);
        chk("R12 readback", rdata, vv & 8'hBF);
        chk("R9 irq", irq, vv[7] & pend);
        chk("R10 wake", wake, s[0] & pend);
      end
    end
    sleep = 1'b0;
    wr(8'h00);

    // R2 rising select
    edge_rise = 1'b1;
    ext_pin = 1'b1; cyc(2);
    chk("R2 latency", rdata[1], 1'b0);
    cyc(1);
    chk("R2 rise sets", rdata[1], 1'b1);
    wr(8'h00);
    ext_pin = 1'b0; cyc(4);
    chk("R2 fall ignored", rdata[1], 1'b0);

    // R3 falling select
    edge_rise = 1'b0;
    cyc(2);
    ext_pin = 1'b1; cyc(4);
    chk("R3 rise ignored", rdata[1], 1'b0);
    ext_pin = 1'b0; cyc(4);
    chk("R3 fall sets", rdata[1], 1'b1);
    wr(8'h00);

    // R4 select changes on a steady pin
    edge_rise = 1'b1; cyc(3);
    chk("R4 low 0->1", rdata[1], 1'b0);
    edge_rise = 1'b0; cyc(3);
    chk("R4 low 1->0", rdata[1], 1'b0);
    ext_pin = 1'b1; cyc(4);
    edge_rise = 1'b1; cyc(3);
    chk("R4 high 0->1", rdata[1], 1'b0);
    edge_rise = 1'b0; cyc(3);
    chk("R4 high 1->0", rdata[1], 1'b0);
    ext_pin = 1'b0; cyc(4);
    wr(8'h00);

    // R5 timer, R8 persistence
    tmr_ovf = 1'b1; cyc(1); tmr_ovf = 1'b0;
    chk("R5 tmr sets", rdata[2], 1'b1);
    ack = 1'b1; cyc(1); ack = 1'b0; cyc(3);
    chk("R8 flag held after ack", rdata[2], 1'b1);
    wr(8'h00);
    chk("R8 write clears", rdata[2], 1'b0);
    tmr_ovf = 1'b1; we = 1'b1; wdata = 8'h00; cyc(1); tmr_ovf = 1'b0; we = 1'b0;
    chk("R5 set beats clear", rdata[2], 1'b1);
    wr(8'h00);

    // R6 each port bit
    for (int b = 0; b < 4; b++) begin
      port[b] = ~port[b]; cyc(4);
      chk($sformatf("R6 bit%0d sets", b), rdata[0], 1'b1);
      rd_port(); cyc(1);
      wr(8'h00); cyc(3);
      chk($sformatf("R6 bit%0d quiet after read", b), rdata[0], 1'b0);
    end

    // R7 read coincides with synchronized change
    port[2] = ~port[2]; cyc(2);
    rd_port(); cyc(3);
    chk("R7 race hides change", rdata[0], 1'b0);
    port[1] = ~port[1]; cyc(1);
    rd_port(); cyc(3);
    chk("R7 early read flags", rdata[0], 1'b1);
    rd_port(); wr(8'h00); cyc(2);

    // R11 global enable handling
    wr(8'h90);
    ack = 1'b1; cyc(1); ack = 1'b0;
    chk("R11 ack clears gie", rdata[7], 1'b0);
    ret = 1'b1; cyc(1); ret = 1'b0;
    chk("R11 ret sets gie", rdata[7], 1'b1);
    ack = 1'b1; ret = 1'b1; cyc(1); ack = 1'b0; ret = 1'b0;
    chk("R11 ack over ret", rdata[7], 1'b0);
    ack = 1'b1; we = 1'b1; wdata = 8'h80; cyc(1); ack = 1'b0; we = 1'b0;
    chk("R11 write over ack", rdata[7], 1'b1);

    // R10 wake without GIE after an external edge
    wr(8'h10); sleep = 1'b1;
    edge_rise = 1'b1; ext_pin = 1'b1; cyc(4);
    chk("R10 wake no gie", wake, 1'b1);
    chk("R9 no irq no gie", irq, 1'b0);

    finish_tb();
  end
endmodule